// File: doc/BRIEF.md
# Dual-Channel IDE Bus-Master Register Block

This block is the byte-wide register file of a two-channel IDE bus-master DMA controller. It decodes a 16-byte I/O window and gives eight bytes to each channel. Bit 3 of the offset picks the channel. Each channel has a command byte, a status byte, a UDMA timing byte and four bytes that store the descriptor table address. One mode/interrupt byte is shared and can be reached at byte 1 of either channel.

The drive side of each channel supplies an interrupt request level, and the DMA side supplies error and interrupt set pulses. The mode register latches the request levels every clock. It also holds one software-written block mask per channel. The block drives one registered, level-sensitive interrupt line: it is asserted when any channel has a latched request whose block bit is clear.

Reads are combinational and have no side effects. Writes take effect on the clock edge that samples the write strobe.

Top module: `ide_bm_regs`

## Requirements
- R1: Offsets 0–7 belong to channel 0 and offsets 8–15 to channel 1. Any offset of 16 or more reads 0xFF, and a write to it changes no register.
- R2: A write to byte 0 of a channel stores data bit 0 (start) and data bit 3 (direction). A read of byte 0 returns those two bits in the same positions, with all other bits zero.
- R3: Status bit 0 always equals the channel's command start bit. Status writes never change it.
- R4: A status write (byte 2) loads data bits 5 and 6 into status bits 5 and 6. Status bits 3, 4 and 7 always read zero.
- R5: Status bit 1 is set by the channel's error set input and status bit 2 by its interrupt set input. Writing a 1 to either bit in a status write clears it, and writing a 0 keeps it. When a set and a clear happen in the same cycle, the set wins.
- R6: A write to byte 1 of either channel changes only mode bits 4 (block channel 0) and 5 (block channel 1). Mode bits 0, 1, 6 and 7 read zero. Reading byte 1 of either channel returns the same value.
- R7: Mode bit 2 takes the level of channel 0's interrupt request input on every clock, and mode bit 3 takes channel 1's. Software writes do not affect these bits.
- R8: The interrupt output equals (mode bit 2 AND NOT mode bit 4) OR (mode bit 3 AND NOT mode bit 5). It is registered, so it follows a mode change one clock later.
- R9: Byte 3 of each channel is that channel's own 8-bit timing register. A write to it leaves the other channel's timing register unchanged.
- R10: Bytes 4–7 of each channel are four independent read/write storage bytes for the descriptor table address.
- R11: While reset is asserted and right after it is released, every register reads 0x00 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte offset into the register space |
| wrEn | input | 1 | Write strobe for the byte at addr |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for the byte at addr |
| chIrq | input | 2 | Interrupt request level from each channel's drive side |
| dmaErrSet | input | 2 | One-cycle pulse per channel that sets status bit 1 |
| dmaIntSet | input | 2 | One-cycle pulse per channel that sets status bit 2 |
| pciIrq | output | 1 | Combined level-sensitive interrupt output |

## Verification
The hardest cases to reach from the ports are those where two sources act on one bit in the same cycle. One is a status write-one-to-clear that lands in the same cycle as an error or interrupt set pulse. Another is a block mask write that lands in the cycle where a channel's request level changes, which exposes the one-cycle lag of the interrupt output. Directed sequences line up these coincidences on both channels and through both aliases of the mode byte. A long stretch of random writes, request toggles and set pulses then hits them again in many combinations. A behavioural model in the bench predicts the read data for the current offset and the interrupt level on every clock.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;

  // Channel and window geometry
  localparam int NUM_CH    = 2;
  localparam int CH_BYTES  = 8;
  localparam int CH_AW     = $clog2(CH_BYTES);
  localparam int WIN_BYTES = NUM_CH * CH_BYTES;
  localparam int WIN_AW    = $clog2(WIN_BYTES);
  localparam int CH_SEL_W  = $clog2(NUM_CH);
  localparam int PRD_BYTES = 4;
  localparam int PRD_LW    = $clog2(PRD_BYTES);

  // Bit positions decoded by software
  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;
  localparam int STS_ACT_BIT   = 0;
  localparam int STS_ERR_BIT   = 1;
  localparam int STS_INT_BIT   = 2;
  localparam int STS_USR_LSB   = 5;
  localparam int STS_USR_W     = 2;
  localparam int MODE_IRQ_LSB  = 2;
  localparam int MODE_BLK_LSB  = 4;

  typedef enum logic [CH_AW-1:0] {
    OFS_CMD  = 3'd0,
    OFS_MODE = 3'd1,
    OFS_STAT = 3'd2,
    OFS_TIM  = 3'd3,
    OFS_PRD0 = 3'd4,
    OFS_PRD1 = 3'd5,
    OFS_PRD2 = 3'd6,
    OFS_PRD3 = 3'd7
  } regOfs_e;

  // Strobes from the decode control to the datapath
  typedef struct packed {
    logic [NUM_CH-1:0]   cmdWr;
    logic [NUM_CH-1:0]   statWr;
    logic [NUM_CH-1:0]   timWr;
    logic [NUM_CH-1:0]   prdWr;
    logic                modeWr;
    logic [PRD_LW-1:0]   prdLane;
    logic                rdHit;
    logic [CH_SEL_W-1:0] rdCh;
    regOfs_e             rdOfs;
  } bmStrobes_t;

endpackage

// File: rtl/ide_bm_ctrl.sv
module ide_bm_ctrl
  import ide_bm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output bmStrobes_t        strb
);

  logic                winHit;
  logic [CH_SEL_W-1:0] chSel;
  regOfs_e             ofs;

  always_comb begin
    winHit = ((addr >> WIN_AW) == '0);
    chSel  = addr[CH_AW +: CH_SEL_W];
    ofs    = regOfs_e'(addr[CH_AW-1:0]);

    strb         = '0;
    strb.rdHit   = winHit;
    strb.rdCh    = chSel;
    strb.rdOfs   = ofs;
    strb.prdLane = addr[PRD_LW-1:0];

    if (wrEn && winHit) begin
      case (ofs)
        OFS_CMD:  strb.cmdWr[chSel]  = 1'b1;
        OFS_MODE: strb.modeWr        = 1'b1;
        OFS_STAT: strb.statWr[chSel] = 1'b1;
        OFS_TIM:  strb.timWr[chSel]  = 1'b1;
        default:  strb.prdWr[chSel]  = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/ide_bm_irq.sv
module ide_bm_irq
  import ide_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chIrq,
  input  logic              modeWr,
  input  logic [7:0]        wrData,
  output logic [7:0]        modeByte,
  output logic              pciIrq
);

  logic [NUM_CH-1:0] irqLat;
  logic [NUM_CH-1:0] blkMask;
  logic [NUM_CH-1:0] chActive;

  // Request levels are latched every clock; masks change only on a write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqLat  <= '0;
      blkMask <= '0;
      pciIrq  <= 1'b0;
    end else begin
      irqLat <= chIrq;
      if (modeWr) blkMask <= wrData[MODE_BLK_LSB +: NUM_CH];
      pciIrq <= |chActive;
    end
  end

  assign chActive = irqLat & ~blkMask;

  always_comb begin
    modeByte = '0;
    modeByte[MODE_IRQ_LSB +: NUM_CH] = irqLat;
    modeByte[MODE_BLK_LSB +: NUM_CH] = blkMask;
  end

endmodule

// File: rtl/ide_bm_dp.sv
module ide_bm_dp
  import ide_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bmStrobes_t        strb,
  input  logic [7:0]        wrData,
  input  logic [NUM_CH-1:0] dmaErrSet,
  input  logic [NUM_CH-1:0] dmaIntSet,
  input  logic [7:0]        modeByte,
  output logic [7:0]        rdData
);

  logic [7:0] chByte [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    logic                 cmdStart;
    logic                 cmdDir;
    logic                 stsErr;
    logic                 stsInt;
    logic [STS_USR_W-1:0] stsUsr;
    logic [7:0]           timReg;
    logic [7:0]           prdReg [PRD_BYTES];
    logic                 clrErr;
    logic                 clrInt;
    logic [7:0]           rdByte;

    assign clrErr = strb.statWr[g] & wrData[STS_ERR_BIT];
    assign clrInt = strb.statWr[g] & wrData[STS_INT_BIT];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmdStart <= 1'b0;
        cmdDir   <= 1'b0;
        stsErr   <= 1'b0;
        stsInt   <= 1'b0;
        stsUsr   <= '0;
        timReg   <= '0;
        for (int b = 0; b < PRD_BYTES; b++) prdReg[b] <= '0;
      end else begin
        if (strb.cmdWr[g]) begin
          cmdStart <= wrData[CMD_START_BIT];
          cmdDir   <= wrData[CMD_DIR_BIT];
        end
        if (strb.statWr[g]) stsUsr <= wrData[STS_USR_LSB +: STS_USR_W];
        // Set pulse has priority over a write-one-to-clear.
        stsErr <= dmaErrSet[g] | (stsErr & ~clrErr);
        stsInt <= dmaIntSet[g] | (stsInt & ~clrInt);
        if (strb.timWr[g]) timReg <= wrData;
        if (strb.prdWr[g]) prdReg[strb.prdLane] <= wrData;
      end
    end

    always_comb begin
      rdByte = '0;
      case (strb.rdOfs)
        OFS_CMD: begin
          rdByte[CMD_START_BIT] = cmdStart;
          rdByte[CMD_DIR_BIT]   = cmdDir;
        end
        OFS_MODE: rdByte = modeByte;
        OFS_STAT: begin
          rdByte[STS_ACT_BIT] = cmdStart;
          rdByte[STS_ERR_BIT] = stsErr;
          rdByte[STS_INT_BIT] = stsInt;
          rdByte[STS_USR_LSB +: STS_USR_W] = stsUsr;
        end
        OFS_TIM: rdByte = timReg;
        default: rdByte = prdReg[strb.prdLane];
      endcase
    end

    assign chByte[g] = rdByte;
  end

  assign rdData = strb.rdHit ? chByte[strb.rdCh] : 8'hFF;

endmodule

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
  import ide_bm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [NUM_CH-1:0] chIrq,
  input  logic [NUM_CH-1:0] dmaErrSet,
  input  logic [NUM_CH-1:0] dmaIntSet,
  output logic              pciIrq
);

  bmStrobes_t strb;
  logic [7:0] modeByte;

  ide_bm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr (addr),
    .wrEn (wrEn),
    .strb (strb)
  );

  ide_bm_irq u_irq (
    .clk      (clk),
    .rstN     (rstN),
    .chIrq    (chIrq),
    .modeWr   (strb.modeWr),
    .wrData   (wrData),
    .modeByte (modeByte),
    .pciIrq   (pciIrq)
  );

  ide_bm_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .dmaErrSet (dmaErrSet),
    .dmaIntSet (dmaIntSet),
    .modeByte  (modeByte),
    .rdData    (rdData)
  );

endmodule

// File: rtl/ide_bm_regs_chk.sv
module ide_bm_regs_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [1:0]        chIrq,
  input logic [7:0]        rdData,
  input logic              pciIrq,
  input logic [7:0]        modeByte
);

  logic pastValid;
  logic modeWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assign modeWrite = wrEn && ((addr >> 4) == '0) && (addr[2:0] == 3'd1);

  // R1
  undefined_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((addr >> 4) != '0) |-> (rdData == 8'hFF));

  // R6
  mode_blk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(modeWrite)) |-> $stable(modeByte[5:4]));

  // R7
  irq_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (modeByte[3:2] == $past(chIrq)));

  // R8
  irq_combine_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (pciIrq == $past((modeByte[2] & ~modeByte[4]) | (modeByte[3] & ~modeByte[5]))));

endmodule

bind ide_bm_regs ide_bm_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addr     (addr),
  .wrEn     (wrEn),
  .chIrq    (chIrq),
  .rdData   (rdData),
  .pciIrq   (pciIrq),
  .modeByte (modeByte)
);

// File: tb/test_ide_bm_regs.sv
module test_ide_bm_regs;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] chIrq = '0;
  logic [1:0] dmaErrSet = '0;
  logic [1:0] dmaIntSet = '0;
  logic [7:0] rdData;
  logic       pciIrq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ide_bm_regs i_ide_bm_regs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .chIrq(chIrq), .dmaErrSet(dmaErrSet),
    .dmaIntSet(dmaIntSet), .pciIrq(pciIrq)
  );

  // Behavioural reference state
  bit       mStart [2];
  bit       mDir   [2];
  bit       mErr   [2];
  bit       mInt   [2];
  bit [1:0] mUsr   [2];
  bit [7:0] mTim   [2];
  bit [7:0] mPrd   [2][4];
  bit [1:0] mIrq;
  bit [1:0] mBlk;
  bit       mOut;

  function automatic bit [7:0] modelRead(input bit [4:0] a);
    int c;
    if (a[4]) return 8'hFF;
    c = int'(a[3]);
    case (a[2:0])
      3'd0:    return {4'b0, mDir[c], 2'b0, mStart[c]};
      3'd1:    return {2'b0, mBlk, mIrq, 2'b0};
      3'd2:    return {1'b0, mUsr[c], 2'b0, mInt[c], mErr[c], mStart[c]};
      3'd3:    return mTim[c];
      default: return mPrd[c][a[1:0]];
    endcase
  endfunction

  function automatic string tagFor(input bit [4:0] a, input bit inRst);
    if (inRst) return "R11";
    if (a[4]) return "R1";
    case (a[2:0])
      3'd0:    return "R2";
      3'd1:    return "R6,R7";
      3'd2:    return "R3,R4,R5";
      3'd3:    return "R9";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        mStart[c] = 0; mDir[c] = 0; mErr[c] = 0; mInt[c] = 0;
        mUsr[c] = 0; mTim[c] = 0;
        for (int b = 0; b < 4; b++) mPrd[c][b] = 0;
      end
      mIrq = 0; mBlk = 0; mOut = 0;
    end else begin
      bit nxtOut;
      nxtOut = (mIrq[0] && !mBlk[0]) || (mIrq[1] && !mBlk[1]);
      for (int c = 0; c < 2; c++) begin
        bit hitCh;
        bit clrE;
        bit clrI;
        hitCh = wrEn && !addr[4] && (int'(addr[3]) == c);
        clrE = hitCh && addr[2:0] == 3'd2 && wrData[1];
        clrI = hitCh && addr[2:0] == 3'd2 && wrData[2];
        if (hitCh && addr[2:0] == 3'd0) begin
          mStart[c] = wrData[0]; mDir[c] = wrData[3];
        end
        if (hitCh && addr[2:0] == 3'd2) mUsr[c] = wrData[6:5];
        if (hitCh && addr[2:0] == 3'd3) mTim[c] = wrData;
        if (hitCh && addr[2]) mPrd[c][addr[1:0]] = wrData;
        mErr[c] = dmaErrSet[c] || (mErr[c] && !clrE);
        mInt[c] = dmaIntSet[c] || (mInt[c] && !clrI);
      end
      if (wrEn && !addr[4] && addr[2:0] == 3'd1) mBlk = wrData[5:4];
      mIrq = chIrq;
      mOut = nxtOut;
    end
  end

  // Compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit [7:0] exp;
      exp = modelRead(addr);
      vectors++;
      if (rdData !== exp) begin
        miscompares++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h", tagFor(addr, !rstN), addr, rdData, exp);
      end
      if (pciIrq !== mOut) begin
        miscompares++;
        $display("FAIL %s pciIrq actual=%0b expected=%0b", rstN ? "R8" : "R11", pciIrq, mOut);
      end
    end
  end

  task automatic cyc(input bit [4:0] a, input bit we, input bit [7:0] d);
    @(negedge clk);
    #1;
    addr = a; wrEn = we; wrData = d;
    dmaErrSet = '0; dmaIntSet = '0;
  endtask

  task automatic readAll();
    for (int a = 0; a < 32; a++) cyc(5'(a), 1'b0, 8'h00);
  endtask

  initial begin
    // R11: reset state
    repeat (4) cyc(5'd2, 1'b0, 8'h00);
    @(negedge clk); #1 rstN = 1'b1;
    readAll();

    // R2, R3: command bits and start mirror, both channels
    cyc(5'd0, 1'b1, 8'hFF);
    cyc(5'd8, 1'b1, 8'h08);
    readAll();
    cyc(5'd2, 1'b1, 8'h00);  // R3: status write cannot clear start
    cyc(5'd2, 1'b0, 8'h00);
    cyc(5'd0, 1'b1, 8'h00);
    cyc(5'd2, 1'b0, 8'h00);

    // R4: user bits, read-zero bits
    cyc(5'd2, 1'b1, 8'hFF);
    cyc(5'd10, 1'b1, 8'h20);
    cyc(5'd2, 1'b0, 8'h00);
    cyc(5'd10, 1'b0, 8'h00);

    // R5: set pulses, write-one-to-clear, set wins over clear
    cyc(5'd2, 1'b0, 8'h00); dmaErrSet = 2'b11; dmaIntSet = 2'b01;
    cyc(5'd10, 1'b0, 8'h00);
    cyc(5'd2, 1'b1, 8'h04);  // clear int only on ch0
    cyc(5'd2, 1'b1, 8'h02); dmaErrSet = 2'b01;  // same-cycle set and clear
    cyc(5'd2, 1'b0, 8'h00);
    cyc(5'd10, 1'b1, 8'h00);  // zero write keeps bits
    cyc(5'd10, 1'b1, 8'h06); dmaIntSet = 2'b10;
    cyc(5'd10, 1'b0, 8'h00);

    // R9, R10: per-channel timing and descriptor bytes
    cyc(5'd3, 1'b1, 8'hA5);
    cyc(5'd11, 1'b1, 8'h3C);
    for (int b = 0; b < 4; b++) cyc(5'(4 + b), 1'b1, 8'(8'h10 + b));
    for (int b = 0; b < 4; b++) cyc(5'(12 + b), 1'b1, 8'(8'hC0 + b * 3));
    readAll();

    // R6, R7, R8: request levels, block masks, both aliases
    cyc(5'd1, 1'b0, 8'h00); chIrq = 2'b01;
    cyc(5'd9, 1'b0, 8'h00);
    cyc(5'd9, 1'b1, 8'hFF);  // only bits 4,5 stick
    cyc(5'd1, 1'b0, 8'h00); chIrq = 2'b11;
    cyc(5'd1, 1'b1, 8'h20);  // unblock ch0
    cyc(5'd9, 1'b0, 8'h00); chIrq = 2'b10;
    cyc(5'd1, 1'b1, 8'h10); chIrq = 2'b00;  // mask change and level change together
    cyc(5'd1, 1'b0, 8'h00); chIrq = 2'b10;
    cyc(5'd1, 1'b0, 8'h00);
    cyc(5'd9, 1'b1, 8'h00);
    repeat (3) cyc(5'd9, 1'b0, 8'h00);

    // R1: writes above the window are ignored
    for (int a = 16; a < 32; a++) cyc(5'(a), 1'b1, 8'hFF);
    readAll();

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      bit [31:0] r;
      r = $urandom;
      cyc(5'(r[4:0]), r[5], 8'(r[15:8]));
      if (r[19:16] == 4'd0) chIrq = 2'(r[21:20]);
      if (r[24:22] == 3'd0) dmaErrSet = 2'(r[26:25]);
      if (r[29:27] == 3'd0) dmaIntSet = 2'(r[31:30]);
    end
    readAll();

    @(negedge clk);
    #1 done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule